// File: doc/BRIEF.md
# Instruction Fetch Address Translation Unit

This block turns the virtual address of an instruction fetch into a physical address, or into a fault code when no translation is allowed. Each request carries a 64-bit translation control word. The block unpacks the privilege mode, the trap level, the partition, the primary context, the address-mask enable and the MMU enable from that word. It then applies, in order of precedence, a bypass of translation, an alignment test and a virtual-address hole test, and finally a TLB lookup. The lookup is made through an external request port, and that port answers in the same cycle.

Faults that come from checks (misalignment, out-of-range and privilege) are recorded in a fault status register. A second fault on top of an earlier one sets an overflow bit in that register. A translation miss loads the tag-access register with the page-aligned address and the context that was used for the lookup. The block keeps a one-entry cache of the last successful translation. The cache is keyed on the full control word and the page. A hit in it gives the answer in one cycle, while a TLB lookup takes two cycles.

Top module: `ifetch_xlate`

## Requirements
- R1: When control bit 0 (hyper-privileged) or bit 1 (red state) is set, the response arrives one cycle after acceptance with fault code 0 and `rsp_pa` equal to the low PA_W bits of the request address, with no TLB query.
- R2: Outside bypass, an address with a nonzero value in bits 1:0 gives fault code 1 (misaligned) and writes fault type 1 into the status register.
- R3: Outside bypass, with control bit 3 (address mask) clear, an aligned address from HOLE_LO to HOLE_HI inclusive gives fault code 2 (out of range) with fault type 3. With bit 3 set, the upper 32 address bits are cleared before any other check and the hole test is skipped.
- R4: A trap level (control bits 18:16) above zero selects context 0. In that case the status register gets context type 2 in bits 5:4 and ASI 0x04 in bits 23:16. Otherwise the context is control bits 47:32, the context type is 0 and the ASI is 0x80.
- R5: With control bit 4 (MMU enable) clear, the lookup is a real lookup with context 0, and a miss gives fault code 5. A miss on a virtual lookup gives fault code 4. The partition comes from control bits 15:8.
- R6: On a miss, the tag-access register becomes the looked-up address with bits 12:0 cleared, ORed with the context that was used. It changes at no other time.
- R7: A hit on an entry marked privileged while control bit 2 is clear gives fault code 3 with fault type 2.
- R8: On a hit, the page offset width is BASE_SHIFT + SHIFT_STEP * page-select. The PA takes the entry bits above that width and the address bits below it.
- R9: Each status write sets bits 1:0 to 3 if bit 0 was already set, and to 1 otherwise. Bit 2 and bit 6 are 0, and the fault type goes in bits 15:7.
- R10: After a successful lookup, a later request with the same control word and an address in the same page is answered one cycle after acceptance with no TLB query. A TLB lookup answers two cycles after acceptance.
- R11: Any accepted request whose control word differs from the cached one invalidates the cache, even when only an undecoded bit differs.
- R12: After reset `req_ready` is 1, and `rsp_valid`, `sfsr` and `tag_access` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Fetch request present |
| req_ready | output | 1 | Block idle, request accepted |
| req_va | input | 64 | Fetch virtual address |
| req_ctl | input | 64 | Translation control word |
| tlb_req | output | 1 | TLB lookup strobe |
| tlb_va | output | 64 | Lookup address (masked) |
| tlb_part | output | 8 | Lookup partition |
| tlb_ctx | output | 16 | Lookup context |
| tlb_real | output | 1 | Real-mode lookup |
| tlb_hit | input | 1 | Lookup matched |
| tlb_pa | input | PA_W | Entry physical address |
| tlb_pg_sel | input | 2 | Entry page-size select |
| tlb_priv | input | 1 | Entry is privileged |
| rsp_valid | output | 1 | Response pulse |
| rsp_pa | output | PA_W | Physical address |
| rsp_fault | output | 3 | Fault code (0 none) |
| sfsr | output | 64 | Fault status register |
| tag_access | output | 64 | Tag-access register |

## Verification
A cache hit and a control-word change can land in the same accept cycle. If the address lies in the cached page but the control word differs, the hit must be refused and the cache dropped. The bench provokes this by repeating a cached address with a control word that differs only in an undecoded bit. It judges the result by a two-cycle answer in place of a one-cycle answer. The bench also sweeps every combination of the mode bits against mapped, privileged, unmapped, misaligned, hole and masked addresses. It predicts the fault, PA, latency, status register and tag-access value with its own arithmetic.

// File: rtl/ifx_pkg.sv
package ifx_pkg;

    typedef struct packed {
        logic        hpriv;
        logic        red;
        logic        priv;
        logic        amask;
        logic        mmu_en;
        logic [7:0]  part;
        logic [2:0]  tl;
        logic [15:0] pctx;
    } ifx_ctl_t;

    typedef enum logic [2:0] {
        FLT_NONE     = 3'd0,
        FLT_MISALIGN = 3'd1,
        FLT_RANGE    = 3'd2,
        FLT_PRIV     = 3'd3,
        FLT_FMISS    = 3'd4,
        FLT_RMISS    = 3'd5
    } ifx_fault_e;

    localparam logic [1:0] CT_PRI  = 2'd0;
    localparam logic [1:0] CT_NUC  = 2'd2;
    localparam logic [7:0] ASI_PRI = 8'h80;
    localparam logic [7:0] ASI_NUC = 8'h04;
    localparam logic [8:0] FT_MISALIGN = 9'd1;
    localparam logic [8:0] FT_PRIV     = 9'd2;
    localparam logic [8:0] FT_RANGE    = 9'd3;
    localparam int unsigned TAG_LOW    = 13;

    function automatic ifx_ctl_t decode_ctl(input logic [63:0] w);
        ifx_ctl_t c;
        c.hpriv  = w[0];
        c.red    = w[1];
        c.priv   = w[2];
        c.amask  = w[3];
        c.mmu_en = w[4];
        c.part   = w[15:8];
        c.tl     = w[18:16];
        c.pctx   = w[47:32];
        return c;
    endfunction

    function automatic logic [63:0] sfsr_next(input logic old0, input logic nuc,
                                              input logic [8:0] ft);
        logic [63:0] s;
        s        = '0;
        s[1:0]   = old0 ? 2'b11 : 2'b01;
        s[5:4]   = nuc ? CT_NUC : CT_PRI;
        s[15:7]  = ft;
        s[23:16] = nuc ? ASI_NUC : ASI_PRI;
        return s;
    endfunction

    function automatic logic [63:0] lo_mask(input int unsigned shift);
        return (64'd1 << shift) - 64'd1;
    endfunction

endpackage

// File: rtl/ifx_front.sv
module ifx_front
    import ifx_pkg::*;
#(
    parameter logic [63:0] HOLE_LO = 64'h0000_8000_0000_0000,
    parameter logic [63:0] HOLE_HI = 64'hFFFF_7FFF_FFFF_FFFF,
    parameter int unsigned AMASK_W = 32
) (
    input  logic [63:0] va,
    input  logic [63:0] ctl_word,
    output logic [63:0] va_m,
    output logic        bypass,
    output logic        misalign,
    output logic        in_hole,
    output logic        nucleus,
    output logic        real_mode,
    output logic        priv,
    output logic [7:0]  part,
    output logic [15:0] ctx
);
    localparam logic [63:0] AMASK = lo_mask(AMASK_W);

    ifx_ctl_t c;

    always_comb begin
        c         = decode_ctl(ctl_word);
        va_m      = c.amask ? (va & AMASK) : va;
        bypass    = c.hpriv | c.red;
        misalign  = |va[1:0];
        in_hole   = !c.amask && (va_m >= HOLE_LO) && (va_m <= HOLE_HI);
        nucleus   = (c.tl != 3'd0);
        real_mode = !c.mmu_en;
        priv      = c.priv;
        part      = c.part;
        if (real_mode || nucleus) ctx = '0;
        else                      ctx = c.pctx;
    end
endmodule

// File: rtl/ifx_cache.sv
module ifx_cache #(
    parameter int unsigned PA_W = 40
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            acc,
    input  logic [63:0]     q_ctl,
    input  logic [63:0]     q_va,
    output logic            hit,
    output logic [PA_W-1:0] hit_pa,
    input  logic            ld,
    input  logic [63:0]     ld_ctl,
    input  logic [63:0]     ld_va,
    input  logic [63:0]     ld_mask,
    input  logic [PA_W-1:0] ld_pa
);
    logic            v_q;
    logic [63:0]     ctl_q;
    logic [63:0]     tag_q;
    logic [63:0]     m_q;
    logic [PA_W-1:0] pa_q;
    logic            same_ctl;

    always_comb begin
        same_ctl = (q_ctl == ctl_q);
        hit      = v_q && same_ctl && ((q_va & ~m_q) == tag_q);
        hit_pa   = (pa_q & ~m_q[PA_W-1:0]) | (q_va[PA_W-1:0] & m_q[PA_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q   <= 1'b0;
            ctl_q <= '0;
            tag_q <= '0;
            m_q   <= '0;
            pa_q  <= '0;
        end else if (ld) begin
            v_q   <= 1'b1;
            ctl_q <= ld_ctl;
            tag_q <= ld_va & ~ld_mask;
            m_q   <= ld_mask;
            pa_q  <= ld_pa;
        end else if (acc && !same_ctl) begin
            v_q <= 1'b0;
        end
    end

    // R11: a mismatching accepted control word leaves no hit for the next cycle
    p_inval_r11: assert property (@(posedge clk) disable iff (rst)
        (acc && !same_ctl && !ld) |=> !v_q);
endmodule

// File: rtl/ifetch_xlate.sv
module ifetch_xlate
    import ifx_pkg::*;
#(
    parameter int unsigned PA_W       = 40,
    parameter int unsigned BASE_SHIFT = 13,
    parameter int unsigned SHIFT_STEP = 3,
    parameter logic [63:0] HOLE_LO    = 64'h0000_8000_0000_0000,
    parameter logic [63:0] HOLE_HI    = 64'hFFFF_7FFF_FFFF_FFFF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [63:0]     req_va,
    input  logic [63:0]     req_ctl,
    output logic            tlb_req,
    output logic [63:0]     tlb_va,
    output logic [7:0]      tlb_part,
    output logic [15:0]     tlb_ctx,
    output logic            tlb_real,
    input  logic            tlb_hit,
    input  logic [PA_W-1:0] tlb_pa,
    input  logic [1:0]      tlb_pg_sel,
    input  logic            tlb_priv,
    output logic            rsp_valid,
    output logic [PA_W-1:0] rsp_pa,
    output logic [2:0]      rsp_fault,
    output logic [63:0]     sfsr,
    output logic [63:0]     tag_access
);
    localparam logic [63:0] TAG_MASK = lo_mask(TAG_LOW);

    logic [63:0] f_va_m;
    logic        f_bypass, f_misalign, f_hole, f_nuc, f_real, f_priv;
    logic [7:0]  f_part;
    logic [15:0] f_ctx;

    ifx_front #(.HOLE_LO(HOLE_LO), .HOLE_HI(HOLE_HI), .AMASK_W(32)) u_front (
        .va(req_va), .ctl_word(req_ctl), .va_m(f_va_m), .bypass(f_bypass),
        .misalign(f_misalign), .in_hole(f_hole), .nucleus(f_nuc),
        .real_mode(f_real), .priv(f_priv), .part(f_part), .ctx(f_ctx)
    );

    logic            busy_q;
    logic [63:0]     p_va_q, p_ctl_q;
    logic            p_priv_q, p_nuc_q, p_real_q;
    logic [7:0]      p_part_q;
    logic [15:0]     p_ctx_q;
    ifx_fault_e      fault_q;

    logic            acc;
    logic            c_hit;
    logic [PA_W-1:0] c_pa;
    logic [63:0]     pg_mask;
    logic [PA_W-1:0] hit_pa;
    logic            priv_viol;
    logic            c_ld;

    always_comb begin
        acc       = req_valid && !busy_q;
        pg_mask   = lo_mask(BASE_SHIFT + SHIFT_STEP * 32'(tlb_pg_sel));
        hit_pa    = (tlb_pa & ~pg_mask[PA_W-1:0]) | (p_va_q[PA_W-1:0] & pg_mask[PA_W-1:0]);
        priv_viol = !p_priv_q && tlb_priv;
        c_ld      = busy_q && tlb_hit && !priv_viol;
    end

    ifx_cache #(.PA_W(PA_W)) u_cache (
        .clk(clk), .rst(rst), .acc(acc), .q_ctl(req_ctl), .q_va(f_va_m),
        .hit(c_hit), .hit_pa(c_pa), .ld(c_ld), .ld_ctl(p_ctl_q), .ld_va(p_va_q),
        .ld_mask(pg_mask), .ld_pa(tlb_pa)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q     <= 1'b0;
            rsp_valid  <= 1'b0;
            rsp_pa     <= '0;
            fault_q    <= FLT_NONE;
            sfsr       <= '0;
            tag_access <= '0;
            p_va_q     <= '0;
            p_ctl_q    <= '0;
            p_priv_q   <= 1'b0;
            p_nuc_q    <= 1'b0;
            p_real_q   <= 1'b0;
            p_part_q   <= '0;
            p_ctx_q    <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (acc) begin
                rsp_pa  <= '0;
                fault_q <= FLT_NONE;
                if (f_bypass) begin
                    rsp_valid <= 1'b1;
                    rsp_pa    <= req_va[PA_W-1:0];
                end else if (f_misalign) begin
                    rsp_valid <= 1'b1;
                    fault_q   <= FLT_MISALIGN;
                    sfsr      <= sfsr_next(sfsr[0], f_nuc, FT_MISALIGN);
                end else if (f_hole) begin
                    rsp_valid <= 1'b1;
                    fault_q   <= FLT_RANGE;
                    sfsr      <= sfsr_next(sfsr[0], f_nuc, FT_RANGE);
                end else if (c_hit) begin
                    rsp_valid <= 1'b1;
                    rsp_pa    <= c_pa;
                end else begin
                    busy_q   <= 1'b1;
                    p_va_q   <= f_va_m;
                    p_ctl_q  <= req_ctl;
                    p_priv_q <= f_priv;
                    p_nuc_q  <= f_nuc;
                    p_real_q <= f_real;
                    p_part_q <= f_part;
                    p_ctx_q  <= f_ctx;
                end
            end else if (busy_q) begin
                busy_q    <= 1'b0;
                rsp_valid <= 1'b1;
                rsp_pa    <= '0;
                if (!tlb_hit) begin
                    fault_q    <= p_real_q ? FLT_RMISS : FLT_FMISS;
                    tag_access <= (p_va_q & ~TAG_MASK) | {48'd0, p_ctx_q};
                end else if (priv_viol) begin
                    fault_q <= FLT_PRIV;
                    sfsr    <= sfsr_next(sfsr[0], p_nuc_q, FT_PRIV);
                end else begin
                    fault_q <= FLT_NONE;
                    rsp_pa  <= hit_pa;
                end
            end
        end
    end

    always_comb begin
        req_ready = !busy_q;
        tlb_req   = busy_q;
        tlb_va    = p_va_q;
        tlb_part  = p_part_q;
        tlb_ctx   = p_ctx_q;
        tlb_real  = p_real_q;
        rsp_fault = fault_q;
    end

    p_bypass_r1: assert property (@(posedge clk) disable iff (rst)
        (acc && f_bypass) |=> (rsp_valid && rsp_fault == FLT_NONE && !tlb_req));
    p_real_ctx_r5: assert property (@(posedge clk) disable iff (rst)
        (tlb_req && tlb_real) |-> (tlb_ctx == 16'd0));
    p_tag_on_miss_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(tag_access) |-> (rsp_valid && (rsp_fault == FLT_FMISS || rsp_fault == FLT_RMISS)));
    p_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sfsr) && $past(sfsr[0])) |-> (sfsr[1:0] == 2'b11));
    p_lookup_len_r10: assert property (@(posedge clk) disable iff (rst)
        tlb_req |=> (!tlb_req && rsp_valid));
endmodule

// File: tb/ifetch_xlate_tb.sv
module ifetch_xlate_tb;
    localparam int PA_W = 40;
    localparam logic [63:0] H_LO = 64'h0000_8000_0000_0000;
    localparam logic [63:0] H_HI = 64'hFFFF_7FFF_FFFF_FFFF;

    logic clk = 0, rst = 1;
    logic req_valid = 0;
    logic [63:0] req_va = '0, req_ctl = '0;
    logic req_ready, tlb_req, tlb_real, tlb_hit, tlb_priv, rsp_valid;
    logic [63:0] tlb_va, sfsr, tag_access;
    logic [7:0] tlb_part;
    logic [15:0] tlb_ctx;
    logic [PA_W-1:0] tlb_pa, rsp_pa;
    logic [1:0] tlb_pg_sel;
    logic [2:0] rsp_fault;

    always #2 clk = ~clk;

    ifetch_xlate #(.PA_W(PA_W)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_ctl(req_ctl), .tlb_req(tlb_req), .tlb_va(tlb_va),
        .tlb_part(tlb_part), .tlb_ctx(tlb_ctx), .tlb_real(tlb_real),
        .tlb_hit(tlb_hit), .tlb_pa(tlb_pa), .tlb_pg_sel(tlb_pg_sel),
        .tlb_priv(tlb_priv), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
        .rsp_fault(rsp_fault), .sfsr(sfsr), .tag_access(tag_access)
    );

    // bench TLB contents
    logic [63:0] e_va[4];
    logic [1:0]  e_sel[4];
    logic [PA_W-1:0] e_pa[4];
    logic        e_priv[4], e_real[4];
    logic [15:0] e_ctx[4];
    logic [7:0]  e_part[4];

    initial begin
        e_va[0]=64'h40_0000; e_sel[0]=0; e_pa[0]=40'h12_3456_6000; e_priv[0]=0; e_real[0]=0; e_ctx[0]=5; e_part[0]=3;
        e_va[1]=64'h80_0000; e_sel[1]=1; e_pa[1]=40'h77_0001_0000; e_priv[1]=1; e_real[1]=0; e_ctx[1]=5; e_part[1]=3;
        e_va[2]=64'h40_0000; e_sel[2]=2; e_pa[2]=40'h0A_0000_0000; e_priv[2]=0; e_real[2]=1; e_ctx[2]=0; e_part[2]=3;
        e_va[3]=64'h40_0000; e_sel[3]=0; e_pa[3]=40'h55_0000_2000; e_priv[3]=0; e_real[3]=0; e_ctx[3]=0; e_part[3]=3;
    end

    function automatic int find(input logic [63:0] va, input logic [7:0] pt,
                                input logic [15:0] cx, input logic rl);
        for (int i = 0; i < 4; i++) begin
            logic [63:0] m;
            m = (64'd1 << (13 + 3 * e_sel[i])) - 1;
            if (e_real[i] == rl && e_part[i] == pt && (rl || e_ctx[i] == cx) &&
                ((va ^ e_va[i]) & ~m) == 0)
                return i;
        end
        return -1;
    endfunction

    always_comb begin
        int k;
        k = find(tlb_va, tlb_part, tlb_ctx, tlb_real);
        tlb_hit = (k >= 0);
        tlb_pa = (k >= 0) ? e_pa[k] : '0;
        tlb_pg_sel = (k >= 0) ? e_sel[k] : 2'd0;
        tlb_priv = (k >= 0) ? e_priv[k] : 1'b0;
    end

    int total = 0, bad = 0, cyc = 0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // bench model state
    logic [63:0] m_sfsr = 0, m_tag = 0, mc_ctl = 0, mc_tag = 0, mc_m = 0;
    logic [PA_W-1:0] mc_pa = 0;
    logic mc_v = 0;

    task automatic model(input logic [63:0] va, input logic [63:0] ctl,
                         output logic [2:0] f, output logic [PA_W-1:0] pa,
                         output int lat, output string tag);
        logic nuc, am, rl;
        logic [63:0] vm, m;
        logic [15:0] cx;
        logic [8:0] ft;
        int k;
        nuc = ctl[18:16] != 0; am = ctl[3]; rl = !ctl[4];
        cx = (nuc || rl) ? 16'd0 : ctl[47:32];
        vm = am ? {32'd0, va[31:0]} : va;
        f = 0; pa = 0; lat = 1; ft = 0;
        if (mc_v && mc_ctl != ctl) mc_v = 0;
        if (ctl[0] || ctl[1]) begin
            pa = va[PA_W-1:0]; tag = "R1";
        end else if (va[1:0] != 0) begin
            f = 1; ft = 1; tag = "R2";
        end else if (!am && vm >= H_LO && vm <= H_HI) begin
            f = 2; ft = 3; tag = "R3";
        end else if (mc_v && ((vm & ~mc_m) == mc_tag)) begin
            pa = (mc_pa & ~mc_m[PA_W-1:0]) | (vm[PA_W-1:0] & mc_m[PA_W-1:0]); tag = "R10";
        end else begin
            lat = 2;
            k = find(vm, ctl[15:8], cx, rl);
            if (k < 0) begin
                f = rl ? 3'd5 : 3'd4; m_tag = (vm & ~64'h1FFF) | {48'd0, cx}; tag = "R5 R6";
            end else if (!ctl[2] && e_priv[k]) begin
                f = 3; ft = 2; tag = "R7";
            end else begin
                m = (64'd1 << (13 + 3 * e_sel[k])) - 1;
                pa = (e_pa[k] & ~m[PA_W-1:0]) | (vm[PA_W-1:0] & m[PA_W-1:0]); tag = "R8";
                mc_v = 1; mc_ctl = ctl; mc_tag = vm & ~m; mc_m = m; mc_pa = e_pa[k];
            end
        end
        if (ft != 0)
            m_sfsr = {40'd0, nuc ? 8'h04 : 8'h80, ft, 1'b0, nuc ? 2'd2 : 2'd0, 2'b00,
                      m_sfsr[0] ? 2'b11 : 2'b01};
    endtask

    task automatic do_req(input logic [63:0] va, input logic [63:0] ctl, input string note);
        logic [2:0] ef; logic [PA_W-1:0] ep; int el, lat; string tg;
        model(va, ctl, ef, ep, el, tg);
        @(negedge clk);
        req_va = va; req_ctl = ctl; req_valid = 1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        lat = 1;
        while (!rsp_valid && lat < 6) begin
            @(negedge clk);
            lat++;
        end
        check({tg, " fault ", note}, 64'(rsp_fault), 64'(ef));
        check({tg, " pa ", note}, 64'(rsp_pa), 64'(ep));
        check({"R10 latency ", note}, 64'(lat), 64'(el));
        check({"R4 R9 sfsr ", note}, sfsr, m_sfsr);
        check({"R6 tag_access ", note}, tag_access, m_tag);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                bad++; total++;
                $display("FAIL watchdog actual=%0d expected<150000", cyc);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        logic [63:0] vas[7];
        vas[0] = 64'h40_1234;              vas[1] = 64'h80_5678;
        vas[2] = 64'h90_0000;              vas[3] = 64'h40_0002;
        vas[4] = 64'h0001_0000_0000_0000;  vas[5] = 64'hFFFF_FFFF_0040_1230;
        vas[6] = 64'h40_1ffc;
        repeat (3) @(posedge clk);
        rst = 0;
        @(negedge clk);
        check("R12 ready", 64'(req_ready), 1);
        check("R12 rsp_valid", 64'(rsp_valid), 0);
        check("R12 sfsr", sfsr, 0);
        check("R12 tag_access", tag_access, 0);

        // R11: cache hit with a changed control word in the same accept cycle
        do_req(64'h40_1234, 64'h0000_0005_0000_0314, "R11 fill");
        do_req(64'h40_1ff0, 64'h0000_0005_0000_0314, "R10 cached hit");
        do_req(64'h40_1ff0, 64'h0000_0005_0010_0314, "R11 ctl change");
        do_req(64'h40_1ff0, 64'h0000_0005_0010_0314, "R10 refill hit");

        for (int tl = 0; tl < 3; tl += 2)
            for (int fl = 0; fl < 32; fl++) begin
                logic [63:0] ctl;
                ctl = {16'd0, 16'd5, 13'd0, 3'(tl), 8'd3, 3'd0, 5'(fl)};
                for (int v = 0; v < 7; v++) do_req(vas[v], ctl, "sweep");
                do_req(vas[0], ctl, "sweep repeat");
            end
        do_req(64'h40_1234, 64'h0000_0005_0000_0714, "R5 other partition");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule